// File: doc/BRIEF.md
# Current-Source Bridge Gate Sequencer

This block drives the four switches of a single-phase H-bridge that is fed from a DC current source. It takes a requested bridge state and turns it into four registered gate enables. Every change of state is make-before-break: the switches of the incoming state are turned on first, and the switches that belong only to the outgoing state are turned off after a programmable number of clock cycles. At no point is the inductor's current path left open.

A capacitor sits across the AC terminals, so the sequencer must never have both diagonal pairs on at the same time. The two requests that would need that overlap are reversing the polarity directly and swapping one zero state for the other. The block splits each of these into two hops through a third state, and each hop gets its own overlap window. The controller above the block changes `req_state` and reads `busy` to know when the bridge has settled.

Top module: `cs_bridge_gate_seq`

## Requirements
- R1: `gate_en` bit 0 drives S1, bit 1 S2, bit 2 S3 and bit 3 S4, where S1/S2 form the left leg and S3/S4 the right leg. In a settled state the state codes give these enables: 2'b00 gives S1+S4 (4'b1001), 2'b01 gives S2+S3 (4'b0110), 2'b10 gives S1+S2 (4'b0011) and 2'b11 gives S3+S4 (4'b1100).
- R2: On every clock cycle, `gate_en` contains at least one complete legal pair (S1+S4, S2+S3, S1+S2 or S3+S4), so the DC current always has a path.
- R3: `gate_en` is never 4'b1111, so both diagonals are never on at once.
- R4: A single-hop change starts on the second rising edge after `req_state` changes. On that edge the union of the old and new sets is asserted and held for the overlap length. The edge after that turns off the switches that belong only to the old set. No edge turns a switch on and another off at the same time.
- R5: A request between 2'b00 and 2'b01 passes through 2'b10 (4'b0011). A request between 2'b10 and 2'b11 passes through 2'b00 (4'b1001). Each hop has its own full overlap.
- R6: A request that changes while an overlap is running does not alter the hop in progress. The latest request is acted on once that hop completes.
- R7: `busy` is high in the cycle after any edge where an overlap was running after that edge, or where the sampled request differs from the applied state. Otherwise it is low.
- R8: While reset is asserted, and right after it is released, `gate_en` is 4'b0011 (state 2'b10) and `busy` is low.
- R9: `ovl_len` is sampled when a hop starts. An overlap of 0 is treated as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_state | input | 2 | Requested bridge state code |
| ovl_len | input | CNT_W | Overlap length in clock cycles |
| gate_en | output | 4 | Registered gate enables, S1 at bit 0 to S4 at bit 3 |
| busy | output | 1 | Transition pending or in progress |

## Verification
The bench targets the two routed swaps, polarity reversal and zero-to-zero. A design that took either swap directly would light all four gates and short the capacitor. It also measures the length of the union window for an overlap of zero, one and a longer value. An off-by-one in the counter would show up as a window that is too short or too long, or as a break that comes before the make. Requests that move during an overlap check that the hop in progress is not retargeted part-way through. Changing it mid-hop could turn off switches whose replacement had not yet been turned on.

// File: rtl/csb_pkg.sv
package csb_pkg;

  typedef enum logic [1:0] {
    BR_POS = 2'b00,
    BR_NEG = 2'b01,
    BR_ZL  = 2'b10,
    BR_ZR  = 2'b11
  } br_state_e;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_OVL  = 1'b1
  } seq_phase_e;

  localparam int unsigned NSW = 4;

  // bit0=S1, bit1=S2 (left leg); bit2=S3, bit3=S4 (right leg)
  function automatic logic [NSW-1:0] gate_mask(input br_state_e s);
    case (s)
      BR_POS:  gate_mask = 4'b1001;
      BR_NEG:  gate_mask = 4'b0110;
      BR_ZL:   gate_mask = 4'b0011;
      default: gate_mask = 4'b1100;
    endcase
  endfunction

endpackage

// File: rtl/csb_route.sv
module csb_route
  import csb_pkg::*;
(
  input  br_state_e      cur_i,
  input  br_state_e      want_i,
  output br_state_e      hop_o,
  output logic [NSW-1:0] union_o,
  output logic [NSW-1:0] hop_mask_o
);

  logic conflict;

  // pairs whose union would close both diagonals differ only in bit 0
  always_comb begin
    conflict = ((cur_i ^ want_i) == 2'b01);
    if (conflict) begin
      hop_o = cur_i[1] ? BR_POS : BR_ZL;
    end else begin
      hop_o = want_i;
    end
    hop_mask_o = gate_mask(hop_o);
    union_o    = gate_mask(cur_i) | hop_mask_o;
  end

endmodule

// File: rtl/csb_hop_timer.sv
module csb_hop_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = (len_i == '0) ? ONE : len_i;
    end else if (run_i && (cnt_q > ONE)) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i || run_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = run_i && (cnt_q == ONE);

  // R9: a running window always holds a live count
  a_r9_cnt_live: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q != '0));

endmodule

// File: rtl/cs_bridge_gate_seq.sv
module cs_bridge_gate_seq
  import csb_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       req_state,
  input  logic [CNT_W-1:0] ovl_len,
  output logic [3:0]       gate_en,
  output logic             busy
);

  br_state_e        want_q, cur_q, cur_d, hop_q, hop_d;
  seq_phase_e       phase_q, phase_d;
  logic [NSW-1:0]   gate_q, gate_d;
  logic             busy_q, busy_d;
  br_state_e        rt_hop;
  logic [NSW-1:0]   rt_union, rt_hop_mask, hop_q_mask;
  logic             start, done;

  csb_route u_route (
    .cur_i      (cur_q),
    .want_i     (want_q),
    .hop_o      (rt_hop),
    .union_o    (rt_union),
    .hop_mask_o (rt_hop_mask)
  );

  csb_hop_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start),
    .run_i  (phase_q == PH_OVL),
    .len_i  (ovl_len),
    .done_o (done)
  );

  assign hop_q_mask = gate_mask(hop_q);
  assign start      = (phase_q == PH_IDLE) && (want_q != cur_q);

  always_comb begin
    phase_d = phase_q;
    cur_d   = cur_q;
    hop_d   = hop_q;
    gate_d  = gate_q;
    if (start) begin
      phase_d = PH_OVL;
      hop_d   = rt_hop;
      gate_d  = rt_union;
    end else if (done) begin
      phase_d = PH_IDLE;
      cur_d   = hop_q;
      gate_d  = hop_q_mask;
    end
    busy_d = (phase_d == PH_OVL) || (br_state_e'(req_state) != cur_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q  <= BR_ZL;
      cur_q   <= BR_ZL;
      hop_q   <= BR_ZL;
      phase_q <= PH_IDLE;
      gate_q  <= 4'b0011;
      busy_q  <= 1'b0;
    end else begin
      want_q  <= br_state_e'(req_state);
      cur_q   <= cur_d;
      hop_q   <= hop_d;
      phase_q <= phase_d;
      gate_q  <= gate_d;
      busy_q  <= busy_d;
    end
  end

  assign gate_en = gate_q;
  assign busy    = busy_q;

  // R3: both diagonals never on together
  a_r3_no_ac_short: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q != 4'b1111);

  // R2: a complete conduction pair is always present
  a_r2_dc_path: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q[0] & gate_q[3]) | (gate_q[1] & gate_q[2]) |
    (gate_q[0] & gate_q[1]) | (gate_q[2] & gate_q[3]));

  // R4: an edge that turns switches off turns none on
  a_r4_make_before_break: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(gate_q) & ~gate_q)) |-> ((gate_q & ~$past(gate_q)) == '0));

  // R7: busy covers every running overlap
  a_r7_busy_in_ovl: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OVL) |-> busy_q);

endmodule

// File: tb/tb_cs_bridge_gate_seq.sv
module tb_cs_bridge_gate_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       req_state = 2'b10;
  logic [CNT_W-1:0] ovl_len = '0;
  logic [3:0]       gate_en;
  logic             busy;

  int n_chk  = 0;
  int n_fail = 0;

  cs_bridge_gate_seq #(.CNT_W(CNT_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_state (req_state),
    .ovl_len   (ovl_len),
    .gate_en   (gate_en),
    .busy      (busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] set_of(input int s);
    case (s)
      0:       return 4'b1001;
      1:       return 4'b0110;
      2:       return 4'b0011;
      default: return 4'b1100;
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int         m_want = 2, m_cur = 2, m_hop = 2, m_left = 0;
  bit         m_ovl = 0, m_busy = 0, cmp_on = 0;
  logic [3:0] m_g = 4'b0011;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_want = 2; m_cur = 2; m_hop = 2; m_left = 0; m_ovl = 0;
      m_g = 4'b0011; m_busy = 0;
    end else begin
      if (!m_ovl) begin
        if (m_want != m_cur) begin
          int h;
          if ((m_cur ^ m_want) == 1) h = (m_cur >= 2) ? 0 : 2;
          else h = m_want;
          m_g = set_of(m_cur) | set_of(h);
          m_hop = h;
          m_left = (ovl_len == 0) ? 1 : int'(ovl_len);
          m_ovl = 1;
        end
      end else if (m_left == 1) begin
        m_g = set_of(m_hop);
        m_cur = m_hop;
        m_ovl = 0;
      end else begin
        m_left = m_left - 1;
      end
      m_want = int'(req_state);
      m_busy = m_ovl || (int'(req_state) != m_cur);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check(m_ovl ? "R4 gates vs model" : "R1 gates vs model", gate_en, m_g);
      check("R7 busy vs model", {3'b0, busy}, {3'b0, m_busy});
      n_chk++;
      if (!((gate_en[0] & gate_en[3]) | (gate_en[1] & gate_en[2]) |
            (gate_en[0] & gate_en[1]) | (gate_en[2] & gate_en[3]))) begin
        n_fail++;
        $display("FAIL R2 no conduction pair actual=%b expected=legal pair", gate_en);
      end
      check("R3 all-on", {3'b0, gate_en == 4'b1111}, 4'b0000);
    end
  end

  // apply a request, then count union cycles and watch for an intermediate set
  task automatic go(input logic [1:0] r, input int len, output int unions,
                    output bit saw_mid, input logic [3:0] mid);
    unions = 0; saw_mid = 0;
    @(negedge clk);
    req_state = r; ovl_len = CNT_W'(len);
    @(negedge clk);
    while (busy) begin
      if ($countones(gate_en) == 3) unions++;
      if (gate_en == mid) saw_mid = 1;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int u;
    bit sm;
    logic [31:0] s;
    repeat (3) @(negedge clk);
    check("R8 reset gates", gate_en, 4'b0011);
    check("R8 reset busy", {3'b0, busy}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release gates", gate_en, 4'b0011);
    check("R8 after release busy", {3'b0, busy}, 4'b0000);
    cmp_on = 1;

    go(2'b00, 5, u, sm, 4'b0000);
    check("R4 union cycles len 5", 4'(u), 4'd5);
    check("R1 settled positive", gate_en, 4'b1001);

    go(2'b01, 3, u, sm, 4'b0011);
    check("R5 polarity swap passes zero 2'b10", {3'b0, sm}, 4'b0001);
    check("R5 two hop union cycles", 4'(u), 4'd6);
    check("R1 settled negative", gate_en, 4'b0110);

    go(2'b11, 0, u, sm, 4'b0000);
    check("R9 zero overlap treated as one", 4'(u), 4'd1);

    go(2'b10, 1, u, sm, 4'b1001);
    check("R5 zero swap passes 2'b00", {3'b0, sm}, 4'b0001);
    check("R1 settled left zero", gate_en, 4'b0011);

    // R6: move the request while an overlap is running
    @(negedge clk);
    req_state = 2'b00; ovl_len = 8'd6;
    repeat (3) @(negedge clk);
    req_state = 2'b11;
    @(negedge clk);
    ovl_len = 8'd1;
    req_state = 2'b01;
    @(negedge clk);
    check("R6 hop not retargeted mid overlap", gate_en, 4'b1011);
    while (busy) @(negedge clk);
    check("R6 latest request applied", gate_en, 4'b0110);

    s = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      req_state = s[17:16];
      ovl_len = CNT_W'(s[21:19]);
      repeat (1 + int'(s[25:23])) @(negedge clk);
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    cmp_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule